// File: doc/BRIEF.md
# Exception Vector Entry Controller

This block is the part of a small processor's system-control unit that decides where execution goes when something interrupts the normal instruction flow. It keeps the mode bits that steer vectoring. A boot-mode bit forces entries into a fixed uncached region. An exception-level bit masks interrupts while a handler runs. A dedicated-interrupt bit and a multi-vector bit choose how interrupt entries are placed. The block also keeps a software exception base register, a saved exception PC, and one programmable entry offset for each of eight interrupt sources.

Each cycle it looks at an exception request, an exception return command and the pending interrupt lines, in that priority order, and picks at most one event. On the next clock edge it presents the chosen entry address together with a one-cycle valid strobe. On that same edge it updates the exception level and, when the event is a fresh entry, saves the current PC. Software changes the state through a single register write port. The redirect outputs, the interrupt-enable status and the error pulse are how the state can be observed.

Top module: `exc_vector_ctrl`

## Requirements
- R1: After synchronous reset the state is: boot mode 1, exception level 0 (`irq_enabled`=1), dedicated-interrupt bit 0, multi-vector bit 0, base 0, EPC 0, every source offset 0x200. `redir_valid` and `base_wr_err` are 0.
- R2: Exception kinds 0 (soft reset) and 1 (NMI) redirect to 0xBFC00000 in every mode and leave the exception level unchanged.
- R3: While boot mode is 1, entries use the fixed region. A general exception (kind 3) goes to 0xBFC00380 and a cache error (kind 2) to 0xBFC00300. An interrupt goes to 0xBFC00380 when the dedicated bit is 0 and to 0xBFC00400 when it is 1, and the multi-vector bit has no effect.
- R4: While boot mode is 0, a general exception goes to base+0x180 and a cache error to base+0x100. An interrupt goes to base+0x180 when the dedicated bit is 0, and to base+0x200 when the dedicated bit is 1 and the multi-vector bit is 0.
- R5: While boot mode is 0 and both the dedicated and multi-vector bits are 1, an interrupt goes to base plus the offset of the winning source, where the lowest-numbered pending line wins.
- R6: A base write (select 2) takes effect only while boot mode is 1. While boot mode is 0 the write is dropped and `base_wr_err` is 1 for exactly the following cycle.
- R7: A general exception or a taken interrupt sets the exception level. Kinds 0, 1 and 2 do not change it.
- R8: While the exception level is 1, `irq_enabled` is 0 and pending interrupts cause no redirect.
- R9: A general exception or interrupt taken with the exception level at 0 saves `cur_pc` into EPC. A general exception taken with the level at 1 leaves EPC unchanged.
- R10: A return command (`eret`) redirects to EPC and clears the exception level.
- R11: A base write ignores data bits 11:0. An offset write (select 8+n for source n) keeps data bits 16:2 and ignores all other bits. Status writes (select 0) set the exception level from bit 0 and boot mode from bit 1. Control writes (select 1) set the dedicated bit from bit 0 and the multi-vector bit from bit 1.
- R12: The redirect appears with `redir_valid`=1 in the cycle after the request. When requests coincide, an exception beats a return and a return beats an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | 1 | Exception request this cycle |
| exc_type | input | 2 | Exception kind: 0 soft reset, 1 NMI, 2 cache error, 3 general |
| irq_pend | input | 8 | Pending interrupt lines, one per source |
| cur_pc | input | 32 | PC of the current instruction |
| eret | input | 1 | Exception return command |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select: 0 status, 1 control, 2 base, 3 EPC, 8+n offset n |
| wr_data | input | 32 | Register write data |
| redir_valid | output | 1 | One-cycle strobe marking a redirect |
| redir_addr | output | 32 | Entry or return address |
| irq_enabled | output | 1 | High while interrupts are accepted |
| base_wr_err | output | 1 | Pulses after a base write attempted outside boot mode |

## Verification
The hardest situation to reach is a general exception that arrives while a handler is already running. To see it at the ports, the saved PC has to survive that nested entry and then appear on the later return. The bench enters an interrupt, raises a general exception with a different PC and checks that the return still goes to the first PC. The illegal base write is observed the same way. The bench leaves boot mode, writes the base, and then checks through a multi-vector interrupt that the entry address still uses the old base. The priority order is exercised by driving an exception, a return and a pending interrupt in the same cycle.

// File: rtl/exc_vec_pkg.sv
// Shared constants and types for the exception vector entry controller.
// Assumes a 32-bit address space and a fixed uncached boot region.
package exc_vec_pkg;
    typedef enum logic [1:0] {
        EXC_SRESET  = 2'd0,
        EXC_NMI     = 2'd1,
        EXC_CACHE   = 2'd2,
        EXC_GENERAL = 2'd3
    } exc_kind_e;

    localparam logic [31:0] BOOT_ENTRY  = 32'hBFC0_0000;
    localparam logic [31:0] FIXED_BASE  = 32'hBFC0_0200;
    localparam logic [31:0] OFF_GENERAL = 32'h0000_0180;
    localparam logic [31:0] OFF_DEDIC   = 32'h0000_0200;
    localparam logic [31:0] OFF_CACHE   = 32'h0000_0100;

    localparam int SEL_STATUS = 0;
    localparam int SEL_CTRL   = 1;
    localparam int SEL_BASE   = 2;
    localparam int SEL_EPC    = 3;
endpackage

// File: rtl/exc_offset_table.sv
// Per-source interrupt entry offset table with a lowest-index-wins arbiter.
// Assumes offsets are word aligned; bits 1:0 of write data are discarded.
module exc_offset_table #(
    parameter int NSRC    = 8,
    parameter int OFF_W   = 17,
    parameter logic [OFF_W-1:0] OFF_RST = 17'h00200,
    localparam int IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [OFF_W-1:0] wr_data,
    input  logic [NSRC-1:0]  irq_pend,
    output logic             irq_any,
    output logic [OFF_W-1:0] sel_off
);
    localparam logic [OFF_W-1:0] ALIGN_MASK = ~OFF_W'(3);

    logic [NSRC-1:0][OFF_W-1:0] off_flat;
    logic [NSRC-1:0]            grant;

    for (genvar i = 0; i < NSRC; i++) begin : g_slot
        logic [OFF_W-1:0] q;
        // Hold one source's offset; software writes replace it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= OFF_RST;
            else if (wr_en && (wr_idx == IDX_W'(i)))
                q <= wr_data & ALIGN_MASK;
        end
        assign off_flat[i] = q;
    end

    // Grant the lowest-numbered pending source.
    always_comb begin
        logic seen;
        seen  = 1'b0;
        grant = '0;
        for (int i = 0; i < NSRC; i++) begin
            grant[i] = irq_pend[i] & ~seen;
            seen     = seen | irq_pend[i];
        end
    end

    // Forward the granted source's offset.
    always_comb begin
        sel_off = '0;
        for (int i = 0; i < NSRC; i++)
            if (grant[i]) sel_off = off_flat[i];
    end

    assign irq_any = |irq_pend;

    p_grant_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~irq_pend) == '0));
    p_grant_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend[0] |-> grant[0]);
endmodule

// File: rtl/exc_status_regs.sv
// Mode bits, exception base and saved PC with their update rules.
// Assumes event updates (enter/return) override same-cycle software writes.
module exc_status_regs
    import exc_vec_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int BASE_LSB = 12,
    parameter int SEL_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              set_exl,
    input  logic              clr_exl,
    input  logic              cap_epc,
    input  logic [ADDR_W-1:0] cur_pc,
    output logic              bev,
    output logic              exl,
    output logic              iv,
    output logic              mvec,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] epc,
    output logic              base_err
);
    localparam logic [ADDR_W-1:0] BASE_MASK = ~((ADDR_W'(1) << BASE_LSB) - ADDR_W'(1));

    logic wr_status, wr_ctrl, wr_base, wr_epc;
    assign wr_status = wr_en && (wr_sel == SEL_W'(SEL_STATUS));
    assign wr_ctrl   = wr_en && (wr_sel == SEL_W'(SEL_CTRL));
    assign wr_base   = wr_en && (wr_sel == SEL_W'(SEL_BASE));
    assign wr_epc    = wr_en && (wr_sel == SEL_W'(SEL_EPC));

    // Boot mode and exception level; entry/return events win over writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bev <= 1'b1;
            exl <= 1'b0;
        end else begin
            if (wr_status) bev <= wr_data[1];
            if (set_exl)        exl <= 1'b1;
            else if (clr_exl)   exl <= 1'b0;
            else if (wr_status) exl <= wr_data[0];
        end
    end

    // Interrupt placement bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iv   <= 1'b0;
            mvec <= 1'b0;
        end else if (wr_ctrl) begin
            iv   <= wr_data[0];
            mvec <= wr_data[1];
        end
    end

    // Base register, writable only in boot mode; flag rejected writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base     <= '0;
            base_err <= 1'b0;
        end else begin
            base_err <= wr_base && !bev;
            if (wr_base && bev) base <= wr_data & BASE_MASK;
        end
    end

    // Saved PC: captured on fresh entry, else software may write it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            epc <= '0;
        else if (cap_epc)
            epc <= cur_pc;
        else if (wr_epc)
            epc <= wr_data;
    end

    p_base_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_base && !bev) |=> ($stable(base) && base_err));
    p_epc_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_exl && exl && !wr_epc) |=> $stable(epc));
    p_exl_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_exl |=> exl);
endmodule

// File: rtl/exc_addr_gen.sv
// Picks this cycle's event (exception > return > interrupt) and forms
// its target address plus the state updates it implies. Purely combinational.
module exc_addr_gen
    import exc_vec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 17
) (
    input  logic              exc_req,
    input  logic [1:0]        exc_type,
    input  logic              eret,
    input  logic              irq_any,
    input  logic              exl,
    input  logic              bev,
    input  logic              iv,
    input  logic              mvec,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] epc,
    input  logic [OFF_W-1:0]  src_off,
    output logic              take,
    output logic [ADDR_W-1:0] addr,
    output logic              set_exl,
    output logic              clr_exl,
    output logic              cap_epc
);
    logic [ADDR_W-1:0] vec_base;
    logic [ADDR_W-1:0] irq_rel;
    exc_kind_e         kind;

    assign vec_base = bev ? ADDR_W'(FIXED_BASE) : base;
    assign kind     = exc_kind_e'(exc_type);

    // Interrupt offset: general, dedicated, or per-source (only outside boot mode).
    always_comb begin
        if (!iv)
            irq_rel = ADDR_W'(OFF_GENERAL);
        else if (mvec && !bev)
            irq_rel = ADDR_W'(src_off);
        else
            irq_rel = ADDR_W'(OFF_DEDIC);
    end

    // Event arbitration and target selection.
    always_comb begin
        take    = 1'b0;
        addr    = '0;
        set_exl = 1'b0;
        clr_exl = 1'b0;
        cap_epc = 1'b0;
        if (exc_req) begin
            take = 1'b1;
            unique case (kind)
                EXC_SRESET, EXC_NMI: addr = ADDR_W'(BOOT_ENTRY);
                EXC_CACHE:           addr = vec_base + ADDR_W'(OFF_CACHE);
                default: begin
                    addr    = vec_base + ADDR_W'(OFF_GENERAL);
                    set_exl = 1'b1;
                    cap_epc = !exl;
                end
            endcase
        end else if (eret) begin
            take    = 1'b1;
            addr    = epc;
            clr_exl = 1'b1;
        end else if (irq_any && !exl) begin
            take    = 1'b1;
            addr    = vec_base + irq_rel;
            set_exl = 1'b1;
            cap_epc = 1'b1;
        end
    end
endmodule

// File: rtl/exc_vector_ctrl.sv
// Top of the exception vector entry controller: ties the mode/state
// registers, the interrupt offset table and the target generator together
// and registers the redirect. Assumes NSRC >= 4 so selects 0..3 fit below
// the offset-table selects.
module exc_vector_ctrl
    import exc_vec_pkg::*;
#(
    parameter int NSRC     = 8,
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 17,
    parameter int BASE_LSB = 12,
    localparam int IDX_W   = $clog2(NSRC),
    localparam int SEL_W   = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic [1:0]        exc_type,
    input  logic [NSRC-1:0]   irq_pend,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic              eret,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_addr,
    output logic              irq_enabled,
    output logic              base_wr_err
);
    logic bev, exl, iv, mvec;
    logic [ADDR_W-1:0] base, epc, nxt_addr;
    logic [OFF_W-1:0]  src_off;
    logic irq_any, take, set_exl, clr_exl, cap_epc;
    logic wr_off;

    assign wr_off = wr_en && wr_sel[SEL_W-1];

    exc_status_regs #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .set_exl(set_exl), .clr_exl(clr_exl), .cap_epc(cap_epc), .cur_pc(cur_pc),
        .bev(bev), .exl(exl), .iv(iv), .mvec(mvec), .base(base), .epc(epc),
        .base_err(base_wr_err)
    );

    exc_offset_table #(.NSRC(NSRC), .OFF_W(OFF_W)) u_offs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_off), .wr_idx(wr_sel[IDX_W-1:0]),
        .wr_data(wr_data[OFF_W-1:0]), .irq_pend(irq_pend),
        .irq_any(irq_any), .sel_off(src_off)
    );

    exc_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_gen (
        .exc_req(exc_req), .exc_type(exc_type), .eret(eret), .irq_any(irq_any),
        .exl(exl), .bev(bev), .iv(iv), .mvec(mvec), .base(base), .epc(epc),
        .src_off(src_off), .take(take), .addr(nxt_addr), .set_exl(set_exl),
        .clr_exl(clr_exl), .cap_epc(cap_epc)
    );

    // Register the redirect so it leaves the block from a flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_addr  <= '0;
        end else begin
            redir_valid <= take;
            if (take) redir_addr <= nxt_addr;
        end
    end

    assign irq_enabled = ~exl;

    p_boot_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && exc_type inside {2'd0, 2'd1}) |=>
            (redir_valid && redir_addr == ADDR_W'(BOOT_ENTRY)));
    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_enabled && !exc_req && !eret) |=> !redir_valid);
    p_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !exc_req) |=> (redir_valid && irq_enabled && redir_addr == $past(epc)));
    p_exc_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && exc_type == 2'd3 && eret) |=> !irq_enabled);
endmodule

// File: tb/exc_vector_ctrl_tb_top.sv
// Scoreboard bench: driver tasks queue the expected redirects, a monitor
// pops and compares them whenever the design reports one.
module exc_vector_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        exc_req;
    logic [1:0]  exc_type;
    logic [7:0]  irq_pend;
    logic [31:0] cur_pc;
    logic        eret;
    logic        wr_en;
    logic [3:0]  wr_sel;
    logic [31:0] wr_data;
    logic        redir_valid;
    logic [31:0] redir_addr;
    logic        irq_enabled;
    logic        base_wr_err;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    exc_vector_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_type(exc_type),
        .irq_pend(irq_pend), .cur_pc(cur_pc), .eret(eret), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .redir_valid(redir_valid),
        .redir_addr(redir_addr), .irq_enabled(irq_enabled), .base_wr_err(base_wr_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each reported redirect against the queue head.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && redir_valid === 1'b1) begin
            if (exp_q.size() == 0)
                chk(1'b0, "R8 unexpected redirect", redir_addr, 32'h0);
            else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(redir_addr === e, t, redir_addr, e);
            end
        end
    end

    // Drive one cycle of event inputs; queue an expectation when asked.
    task automatic step(input bit ex, input logic [1:0] kind, input bit ret,
                        input logic [7:0] pend, input logic [31:0] pc,
                        input bit expect_redir, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exc_req = ex; exc_type = kind; eret = ret; irq_pend = pend; cur_pc = pc;
        if (expect_redir) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        exc_req = 1'b0; eret = 1'b0; irq_pend = '0;
    endtask

    task automatic wr(input logic [3:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; exc_req = 1'b0; exc_type = 2'd0; irq_pend = '0; cur_pc = '0;
        eret = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(irq_enabled === 1'b1, "R1 irq_enabled after reset", {31'h0, irq_enabled}, 32'h1);
        chk(redir_valid === 1'b0, "R1 redir_valid after reset", {31'h0, redir_valid}, 32'h0);
        chk(base_wr_err === 1'b0, "R1 error flag after reset", {31'h0, base_wr_err}, 32'h0);

        // R2 soft reset and NMI in boot mode
        step(1, 2'd0, 0, 8'h00, 32'h100, 1, 32'hBFC0_0000, "R2 soft reset entry");
        step(1, 2'd1, 0, 8'h00, 32'h104, 1, 32'hBFC0_0000, "R2 NMI entry");
        chk(irq_enabled === 1'b1, "R2 level unchanged by NMI", {31'h0, irq_enabled}, 32'h1);

        // R3 cache error in boot mode; R7 it does not raise the level
        step(1, 2'd2, 0, 8'h00, 32'h108, 1, 32'hBFC0_0300, "R3 cache error boot entry");
        chk(irq_enabled === 1'b1, "R7 cache error keeps level", {31'h0, irq_enabled}, 32'h1);

        // R3 general, R7 level set, R10 return, R9 capture
        step(1, 2'd3, 0, 8'h00, 32'h0000_1000, 1, 32'hBFC0_0380, "R3 general boot entry");
        chk(irq_enabled === 1'b0, "R7 general sets level", {31'h0, irq_enabled}, 32'h0);
        step(0, 2'd0, 1, 8'h00, 32'h0, 1, 32'h0000_1000, "R10 return to saved PC R9");
        chk(irq_enabled === 1'b1, "R10 return clears level", {31'h0, irq_enabled}, 32'h1);

        // Nested: interrupt then general exception while level is 1
        step(0, 2'd0, 0, 8'h08, 32'h0000_2000, 1, 32'hBFC0_0380, "R3 boot interrupt no dedicated");
        step(1, 2'd3, 0, 8'h00, 32'h0000_3000, 1, 32'hBFC0_0380, "R3 nested general entry");
        step(0, 2'd0, 0, 8'h08, 32'h0000_3100, 0, 32'h0, "R8 masked");
        chk(irq_enabled === 1'b0, "R8 irq_enabled low in handler", {31'h0, irq_enabled}, 32'h0);
        step(0, 2'd0, 1, 8'h00, 32'h0, 1, 32'h0000_2000, "R9 nested entry kept EPC");

        // R3 dedicated bit in boot mode; multi-vector ignored there
        wr(4'd1, 32'h3);
        step(0, 2'd0, 0, 8'h01, 32'h0000_2100, 1, 32'hBFC0_0400, "R3 boot interrupt dedicated");
        step(0, 2'd0, 1, 8'h00, 32'h0, 1, 32'h0000_2100, "R10 return after boot irq");

        // R11 base alignment and offset masking
        wr(4'd2, 32'h9D00_0ABC);
        wr(4'd11, 32'h0000_0274);
        wr(4'd13, 32'hFFFF_0302);
        wr(4'd0, 32'h0);   // leave boot mode, level 0

        // R4 outside boot mode with multi-vector on: plain general and cache
        step(1, 2'd3, 0, 8'h00, 32'h0000_4000, 1, 32'h9D00_0180, "R4 general base entry R11");
        step(0, 2'd0, 1, 8'h00, 32'h0, 1, 32'h0000_4000, "R10 return after general");
        step(1, 2'd2, 0, 8'h00, 32'h0000_4100, 1, 32'h9D00_0100, "R4 cache base entry");

        // R5 multi-vector selection and lowest-wins
        step(0, 2'd0, 0, 8'h28, 32'h0000_4200, 1, 32'h9D00_0274, "R5 lowest pending source 3");
        step(0, 2'd0, 1, 8'h00, 32'h0, 1, 32'h0000_4200, "R10 return after src3");
        step(0, 2'd0, 0, 8'h20, 32'h0000_4300, 1, 32'h9D01_0300, "R11 offset masked src5");
        step(0, 2'd0, 1, 8'h00, 32'h0, 1, 32'h0000_4300, "R10 return after src5");
        step(0, 2'd0, 0, 8'h80, 32'h0000_4400, 1, 32'h9D00_0200, "R1 default offset src7");
        step(0, 2'd0, 1, 8'h00, 32'h0, 1, 32'h0000_4400, "R10 return after src7");

        // R4 dedicated without multi-vector, then general offset
        wr(4'd1, 32'h1);
        step(0, 2'd0, 0, 8'h40, 32'h0000_4500, 1, 32'h9D00_0200, "R4 dedicated interrupt");
        step(0, 2'd0, 1, 8'h00, 32'h0, 1, 32'h0000_4500, "R10 return dedicated");
        wr(4'd1, 32'h2);
        step(0, 2'd0, 0, 8'h40, 32'h0000_4600, 1, 32'h9D00_0180, "R4 interrupt general offset");
        step(0, 2'd0, 1, 8'h00, 32'h0, 1, 32'h0000_4600, "R10 return general irq");

        // R2 soft reset still fixed outside boot mode
        step(1, 2'd0, 0, 8'h00, 32'h0000_4700, 1, 32'hBFC0_0000, "R2 soft reset outside boot");

        // R6 base write rejected outside boot mode
        wr(4'd1, 32'h3);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 4'd2; wr_data = 32'h8000_0000;
        @(negedge clk);
        wr_en = 1'b0;
        chk(base_wr_err === 1'b1, "R6 error pulse", {31'h0, base_wr_err}, 32'h1);
        @(negedge clk);
        chk(base_wr_err === 1'b0, "R6 error pulse one cycle", {31'h0, base_wr_err}, 32'h0);
        step(0, 2'd0, 0, 8'h08, 32'h0000_5000, 1, 32'h9D00_0274, "R6 base unchanged");
        step(0, 2'd0, 1, 8'h00, 32'h0, 1, 32'h0000_5000, "R10 return after R6");

        // R12 priority: exception over return over interrupt
        step(1, 2'd3, 1, 8'h01, 32'h0000_6000, 1, 32'h9D00_0180, "R12 exception wins");
        chk(irq_enabled === 1'b0, "R12 level set by winner", {31'h0, irq_enabled}, 32'h0);
        step(0, 2'd0, 1, 8'h01, 32'h0000_6100, 1, 32'h0000_6000, "R12 return beats interrupt");
        chk(irq_enabled === 1'b1, "R12 level cleared", {31'h0, irq_enabled}, 32'h1);
        step(0, 2'd0, 0, 8'h01, 32'h0000_6200, 1, 32'h9D00_0200, "R12 interrupt src0");
        step(0, 2'd0, 1, 8'h00, 32'h0, 1, 32'h0000_6200, "R10 final return");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R12 missing redirect", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule